// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block sits next to a free-running timer counter and watches one input pin that has already been synchronised. When the pin makes a transition of the kind chosen by a two-bit mode field, the block stores the counter value from that clock into a capture register. Each arming gives two slots. The first qualifying edge fills slot 0 and the second fills slot 1. After that the unit ignores the pin until it is rearmed.

A one-cycle event strobe tells the surrounding timer that a capture has completed. A count-select bit chooses whether the strobe follows the first capture or the second. The unit is rearmed, which sends the slot sequence back to slot 0, in two ways: by a rearm strobe (the timer raises it when software clears the capture status flag), or by the mode field moving from "off" to any edge mode. Captures happen only while the pin direction bit marks the pin as an input.

The slot sequencer is a three-state machine:
- `SEQ_FIRST`: waiting to fill slot 0.
- `SEQ_SECOND`: waiting to fill slot 1.
- `SEQ_FULL`: both slots are taken.

Transitions:
- `TAKE_FIRST`: `SEQ_FIRST` to `SEQ_SECOND`, on a qualifying edge.
- `TAKE_SECOND`: `SEQ_SECOND` to `SEQ_FULL`, on a qualifying edge.
- `RESTART`: any state to `SEQ_FIRST`, on a rearm or an arming mode change.
- `HOLD`: the state is kept when neither of the above applies.

Top module: `dual_edge_capture`

## Requirements
- R1: While reset is asserted and after it is released, both capture registers read 0 and the event strobe is low.
- R2: Mode encoding: 0 means no capture, 1 means rising edges (pin 0 then 1), 2 means falling edges (pin 1 then 0), and 3 means both edges. An edge of the other kind stores nothing.
- R3: When `pin_is_input` is 0, no edge stores a value and no event strobe is produced.
- R4: The first qualifying edge after arming stores the `count_in` value present at that clock edge into `cap_slot0`, and the second stores it into `cap_slot1`. Either value is visible one cycle later.
- R5: Once both slots are full, further edges leave both registers unchanged and produce no strobe.
- R6: `cap_event` is a one-cycle pulse in the same cycle as the register update. It follows the slot 0 capture when `two_shot` is 0, and the slot 1 capture when `two_shot` is 1.
- R7: A `rearm` pulse returns the sequence to slot 0 and leaves the stored values unchanged. An edge in the same cycle as `rearm` is dropped.
- R8: A change of `cap_mode` from 0 to a non-zero value returns the sequence to slot 0. An edge in that same cycle is dropped. A change between two non-zero modes does not rearm.
- R9: The pin's previous sample is updated on every clock, whatever the mode or direction. A level change that happens while capture is disabled is therefore never seen later as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Synchronised capture pin level |
| count_in | input | 32 | Live counter value |
| cap_mode | input | 2 | Edge select: 0 off, 1 rising, 2 falling, 3 both |
| two_shot | input | 1 | 0: strobe after first capture, 1: after second |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| rearm | input | 1 | One-cycle pulse restarting the slot sequence |
| cap_slot0 | output | 32 | First captured counter value |
| cap_slot1 | output | 32 | Second captured counter value |
| cap_event | output | 1 | Capture-complete pulse |

## Verification
The assertions check the following on every cycle:
- the direction bit and the "off" mode freeze both registers;
- any change in a slot register equals the counter value from the previous clock;
- the two slots never change together;
- a strobe never appears without an input pin and an active mode in the previous cycle;
- a rearm cycle never stores a value.

Only the bench's scenarios can show the properties that depend on history:
- the slot order;
- saturation after two captures;
- which capture the strobe follows under each count-select setting;
- the priority of rearm and arming over a coincident edge;
- an edge hidden by a disabled period staying unseen.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
    // Number of capture slots per arming.
    localparam int SLOT_COUNT = 2;
    localparam int SLOT_IDX_W = $clog2(SLOT_COUNT);

    typedef enum logic [1:0] {
        CAPM_OFF  = 2'd0,
        CAPM_RISE = 2'd1,
        CAPM_FALL = 2'd2,
        CAPM_ANY  = 2'd3
    } capm_e;

    typedef enum logic [1:0] {
        SEQ_FIRST  = 2'd0,
        SEQ_SECOND = 2'd1,
        SEQ_FULL   = 2'd2
    } seq_e;
endpackage

// File: rtl/dec_edge_qual.sv
`timescale 1ns/1ps
// Finds a qualifying transition on the pin. The previous sample is kept
// on every clock, independent of mode or direction.
module dec_edge_qual
    import dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] cap_mode,
    output logic       edge_hit
);
    logic  pin_prev;
    logic  rose;
    logic  fell;
    capm_e mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
        end else begin
            pin_prev <= pin_in;
        end
    end

    assign rose   = pin_in & ~pin_prev;
    assign fell   = ~pin_in & pin_prev;
    assign mode_q = capm_e'(cap_mode);

    always_comb begin
        unique case (mode_q)
            CAPM_OFF:  edge_hit = 1'b0;
            CAPM_RISE: edge_hit = rose;
            CAPM_FALL: edge_hit = fell;
            CAPM_ANY:  edge_hit = rose | fell;
            default:   edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dec_arm_detect.sv
`timescale 1ns/1ps
// Produces a restart request on an explicit rearm, or when the mode
// leaves "off" for any edge mode.
module dec_arm_detect
    import dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cap_mode,
    input  logic       rearm,
    output logic       restart
);
    logic [1:0] mode_prev;
    logic       mode_armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_prev <= CAPM_OFF;
        end else begin
            mode_prev <= cap_mode;
        end
    end

    assign mode_armed = (mode_prev == CAPM_OFF) && (cap_mode != CAPM_OFF);
    assign restart    = rearm | mode_armed;
endmodule

// File: rtl/dec_slot_seq.sv
`timescale 1ns/1ps
// Slot sequencer: decides which slot (if any) a qualified edge fills,
// and whether that capture completes the event.
module dec_slot_seq
    import dec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  edge_ok,
    input  logic                  restart,
    input  logic                  two_shot,
    output logic [SLOT_COUNT-1:0] slot_we,
    output logic                  cap_event
);
    seq_e state_q;
    seq_e state_d;
    logic take;
    logic fire_d;

    // A restart always wins over an edge in the same cycle.
    assign take = edge_ok & ~restart;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = state_q;
        slot_we = '0;
        fire_d  = 1'b0;
        unique case (state_q)
            SEQ_FIRST: begin
                if (take) begin
                    slot_we[0] = 1'b1;
                    fire_d     = ~two_shot;
                    state_d    = SEQ_SECOND;
                end
            end
            SEQ_SECOND: begin
                if (take) begin
                    slot_we[1] = 1'b1;
                    fire_d     = two_shot;
                    state_d    = SEQ_FULL;
                end
            end
            SEQ_FULL: begin
                state_d = SEQ_FULL;
            end
            default: begin
                state_d = SEQ_FIRST;
            end
        endcase
        if (restart) begin
            state_d = SEQ_FIRST;
        end
    end

    // Strobe is registered so it lines up with the slot update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_event <= 1'b0;
        end else begin
            cap_event <= fire_d;
        end
    end
endmodule

// File: rtl/dec_slot_bank.sv
`timescale 1ns/1ps
// Holds the captured counter values, one register per slot.
module dec_slot_bank
    import dec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SLOT_COUNT-1:0] slot_we,
    input  logic [WIDTH-1:0]      value_in,
    output logic [WIDTH-1:0]      slot_val [SLOT_COUNT]
);
    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_val[g] <= '0;
            end else if (slot_we[g]) begin
                slot_val[g] <= value_in;
            end
        end
    end
endmodule

// File: rtl/dual_edge_capture.sv
`timescale 1ns/1ps
module dual_edge_capture
    import dec_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [WIDTH-1:0] count_in,
    input  logic [1:0]       cap_mode,
    input  logic             two_shot,
    input  logic             pin_is_input,
    input  logic             rearm,
    output logic [WIDTH-1:0] cap_slot0,
    output logic [WIDTH-1:0] cap_slot1,
    output logic             cap_event
);
    logic                  edge_hit;
    logic                  restart;
    logic [SLOT_COUNT-1:0] slot_we;
    logic [WIDTH-1:0]      slot_val [SLOT_COUNT];

    dec_edge_qual u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .cap_mode (cap_mode),
        .edge_hit (edge_hit)
    );

    dec_arm_detect u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_mode (cap_mode),
        .rearm    (rearm),
        .restart  (restart)
    );

    dec_slot_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_ok   (edge_hit & pin_is_input),
        .restart   (restart),
        .two_shot  (two_shot),
        .slot_we   (slot_we),
        .cap_event (cap_event)
    );

    dec_slot_bank #(.WIDTH(WIDTH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_we  (slot_we),
        .value_in (count_in),
        .slot_val (slot_val)
    );

    assign cap_slot0 = slot_val[0];
    assign cap_slot1 = slot_val[1];
endmodule

// File: rtl/dec_checker.sv
`timescale 1ns/1ps
module dec_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_in,
    input logic [WIDTH-1:0] count_in,
    input logic [1:0]       cap_mode,
    input logic             two_shot,
    input logic             pin_is_input,
    input logic             rearm,
    input logic [WIDTH-1:0] cap_slot0,
    input logic [WIDTH-1:0] cap_slot1,
    input logic             cap_event
);
    AST_OUTPUT_DIR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input |=> ($stable(cap_slot0) && $stable(cap_slot1) && !cap_event)); // R3

    AST_OFF_MODE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == 2'd0) |=> ($stable(cap_slot0) && $stable(cap_slot1) && !cap_event)); // R2

    AST_SLOT0_GETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_slot0) |-> (cap_slot0 == $past(count_in))); // R4

    AST_SLOT1_GETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_slot1) |-> (cap_slot1 == $past(count_in))); // R4

    AST_ONE_SLOT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(cap_slot0) && !$stable(cap_slot1))); // R4

    AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> ($past(pin_is_input) && ($past(cap_mode) != 2'd0) && !$past(rearm))); // R6

    AST_REARM_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> ($stable(cap_slot0) && $stable(cap_slot1) && !cap_event)); // R7
endmodule

bind dual_edge_capture dec_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_edge_capture_tb_top.sv
`timescale 1ns/1ps
module dual_edge_capture_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin_in = 1'b0;
    logic [W-1:0] count_in = '0;
    logic [1:0]   cap_mode = 2'd0;
    logic         two_shot = 1'b0;
    logic         pin_is_input = 1'b0;
    logic         rearm = 1'b0;
    logic [W-1:0] cap_slot0;
    logic [W-1:0] cap_slot1;
    logic         cap_event;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state, built from the requirements.
    int           m_idx = 0;
    logic         m_prev_pin = 1'b0;
    logic [1:0]   m_prev_mode = 2'd0;
    logic [W-1:0] e_c0 = '0;
    logic [W-1:0] e_c1 = '0;
    logic         e_ev = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dual_edge_capture #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(count_in),
        .cap_mode(cap_mode), .two_shot(two_shot), .pin_is_input(pin_is_input),
        .rearm(rearm), .cap_slot0(cap_slot0), .cap_slot1(cap_slot1),
        .cap_event(cap_event)
    );

    function automatic logic qualifies(logic prev, logic cur, logic [1:0] md);
        case (md)
            2'd1:    return !prev && cur;
            2'd2:    return prev && !cur;
            2'd3:    return prev != cur;
            default: return 1'b0;
        endcase
    endfunction

    task automatic compare(string tag);
        checks++;
        if (cap_slot0 !== e_c0 || cap_slot1 !== e_c1 || cap_event !== e_ev) begin
            errors++;
            $display("FAIL %s: got c0=%h c1=%h ev=%b expected c0=%h c1=%h ev=%b",
                     tag, cap_slot0, cap_slot1, cap_event, e_c0, e_c1, e_ev);
        end
    endtask

    // Called at a falling edge with inputs already driven.
    task automatic tick(string tag);
        logic ed, rs, hit;
        ed  = qualifies(m_prev_pin, pin_in, cap_mode);
        rs  = rearm || (m_prev_mode == 2'd0 && cap_mode != 2'd0);
        hit = ed && pin_is_input && !rs && (m_idx < 2);
        e_ev = 1'b0;
        if (hit) begin
            if (m_idx == 0) begin
                e_c0 = count_in; e_ev = !two_shot; m_idx = 1;
            end else begin
                e_c1 = count_in; e_ev = two_shot; m_idx = 2;
            end
        end
        if (rs) m_idx = 0;
        m_prev_pin  = pin_in;
        m_prev_mode = cap_mode;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drv(logic p, logic [1:0] m, logic d, logic s, logic r,
                       logic [W-1:0] c, string tag);
        pin_in = p; cap_mode = m; pin_is_input = d; two_shot = s;
        rearm = r; count_in = c;
        tick(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_c0de);
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // Rising mode, event after first capture.
        drv(0, 2'd1, 1, 0, 0, 32'h0, "R8 arm");
        drv(1, 2'd1, 1, 0, 0, 32'h1111_1111, "R4 R6 slot0");
        drv(0, 2'd1, 1, 0, 0, 32'h0BAD_0001, "R2 fall ignored");
        drv(1, 2'd1, 1, 0, 0, 32'h2222_2222, "R4 slot1");
        drv(0, 2'd1, 1, 0, 0, 32'h0, "R5");
        drv(1, 2'd1, 1, 0, 0, 32'h3333_3333, "R5 full ignored");
        // Rearm, then event on second capture.
        drv(0, 2'd1, 1, 1, 1, 32'h0, "R7 rearm");
        drv(1, 2'd1, 1, 1, 0, 32'hAAAA_0001, "R6 slot0 no event");
        drv(0, 2'd1, 1, 1, 0, 32'h0, "R6");
        drv(1, 2'd1, 1, 1, 0, 32'hAAAA_0002, "R6 slot1 event");
        // Rearm coinciding with an edge.
        drv(0, 2'd1, 1, 0, 0, 32'h0, "R7");
        drv(1, 2'd1, 1, 0, 1, 32'hDEAD_0001, "R7 edge dropped");
        drv(0, 2'd1, 1, 0, 0, 32'h0, "R7");
        drv(1, 2'd1, 1, 0, 0, 32'hBBBB_0001, "R7 refill slot0");
        // Output direction blocks captures.
        drv(0, 2'd3, 0, 0, 0, 32'hDEAD_0002, "R3");
        drv(1, 2'd3, 0, 0, 0, 32'hDEAD_0003, "R3 no capture");
        drv(0, 2'd3, 0, 0, 0, 32'hDEAD_0004, "R3 no capture");
        // Falling mode, then both-edges mode after rearm.
        drv(0, 2'd2, 1, 0, 1, 32'h0, "R2 rearm");
        drv(1, 2'd2, 1, 0, 0, 32'hDEAD_0005, "R2 rise ignored");
        drv(0, 2'd2, 1, 0, 0, 32'hCCCC_0001, "R2 fall slot0");
        drv(0, 2'd3, 1, 0, 1, 32'h0, "R7 rearm");
        drv(1, 2'd3, 1, 1, 0, 32'hCCCC_0002, "R2 any rise");
        drv(0, 2'd3, 1, 1, 0, 32'hCCCC_0003, "R2 any fall");
        // Hidden edge while off, then arm with steady high pin.
        drv(0, 2'd0, 1, 0, 0, 32'h0, "R9");
        drv(1, 2'd0, 1, 0, 0, 32'hDEAD_0006, "R9 off");
        drv(1, 2'd1, 1, 0, 0, 32'hDEAD_0007, "R8 R9 arm");
        drv(1, 2'd1, 1, 0, 0, 32'hDEAD_0008, "R9 steady high");
        drv(0, 2'd1, 1, 0, 0, 32'h0, "R9");
        drv(1, 2'd1, 1, 0, 0, 32'hEEEE_0001, "R9 real rise");
        // Arming edge coincides with pin edge; mode change 1->3 no rearm.
        drv(0, 2'd0, 1, 0, 0, 32'h0, "R8");
        drv(1, 2'd3, 1, 0, 0, 32'hDEAD_0009, "R8 arm drops edge");
        drv(0, 2'd3, 1, 0, 0, 32'hF0F0_0001, "R8 slot0");
        drv(1, 2'd1, 1, 0, 0, 32'hF0F0_0002, "R8 slot1");
        drv(0, 2'd3, 1, 0, 0, 32'hDEAD_000A, "R8 no rearm between modes");

        // Constrained random phase.
        for (int i = 0; i < 4000; i++) begin
            logic p, d, s, r;
            logic [1:0] m;
            p = ($urandom % 3 == 0) ? ~pin_in : pin_in;
            m = ($urandom % 40 == 0) ? 2'($urandom) : cap_mode;
            d = ($urandom % 10 != 0);
            s = ($urandom % 30 == 0) ? ~two_shot : two_shot;
            r = ($urandom % 12 == 0);
            drv(p, m, d, s, r, $urandom, "R4 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule